// File: doc/BRIEF.md
# Sprite and Playfield Collision Latch

This block watches every displayed pixel for overlaps between objects. On each valid pixel it takes the six raw bitplane bits and the 2-bit colour codes of eight sprites. It reduces them to two plane groups and four sprite groups:

- The odd plane group is made of planes 1, 3 and 5.
- The even plane group is made of planes 2, 4 and 6.
- Sprite group k is made of sprites 2k and 2k+1.

Every pair of groups that are present together sets its own flag in a 16-bit sticky status register.

Software polls the register through a one-cycle read strobe. The strobe returns the accumulated flags and empties the register in the same cycle. A configuration input decides two things. It sets which planes take part in plane-group detection, and the value each plane must match. It also sets whether each odd-numbered sprite is merged into its group. Detection uses the raw plane bits only, so the display mode (one playfield or two) has no effect on it.

Top module: `collision_latch`

## Requirements
- R1: After reset, and until a pixel is accepted, a read returns 16'h0000.
- R2: Bit 15 of the status always reads as 0.
- R3: The flags for sprite groups against each other sit at these bits: group2&group3 at bit 14, group1&group3 at bit 13, group1&group2 at bit 12, group0&group3 at bit 11, group0&group2 at bit 10, group0&group1 at bit 9.
- R4: The flags for the even plane group against sprite groups 3, 2, 1 and 0 sit at bits 8, 7, 6 and 5 respectively.
- R5: The flags for the odd plane group against sprite groups 3, 2, 1 and 0 sit at bits 4, 3, 2 and 1 respectively. The flag for the even plane group against the odd plane group sits at bit 0.
- R6: Plane n (n=1..6) is `plane_bits[n-1]`. A plane group is hit when every plane in it whose `plane_en` bit is 1 has a `plane_bits` value equal to its `plane_match` bit. A plane group with no enabled planes is always hit.
- R7: Sprite i is present when `spr_code[2i+1:2i]` is nonzero. Group k always includes sprite 2k. Sprite 2k+1 is included only while `odd_spr_en[k]` is 1.
- R8: A pixel presented while `pix_valid` is 0 sets no flag.
- R9: A flag stays set across later pixels until a read clears it. Flags from different pixels accumulate.
- R10: While `rd_en` is 1, `rd_data` shows the register contents, and the register is cleared at the end of that cycle. While `rd_en` is 0, `rd_data` is 0.
- R11: When a read and a collision fall in the same cycle, the read returns the earlier contents. The new flag appears in the register after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Current pixel is in the visible area |
| plane_bits | input | 6 | Raw bitplane bits; bit n-1 is plane n |
| spr_code | input | 16 | Colour codes of sprites 0..7, two bits each |
| plane_en | input | 6 | Plane takes part in group detection |
| plane_match | input | 6 | Value each enabled plane must have |
| odd_spr_en | input | 4 | Merge sprite 2k+1 into group k |
| rd_en | input | 1 | Read strobe; clears the register |
| rd_data | output | 16 | Status value during a read, else 0 |

## Verification
A pixel accepted at a rising edge shows up in the register after that same edge. The earliest read that can observe it therefore starts one cycle after the pixel cycle. A read is combinational, so `rd_data` is valid within the strobe cycle, and the clear takes effect at the closing edge of that cycle. The bench drives inputs on falling edges. It places each pixel one cycle ahead of the read that checks it, and samples `rd_data` shortly after raising the strobe. It then reads a second time to confirm the clear and the survival of any same-cycle collision.

// File: rtl/clx_pkg.sv
package clx_pkg;
    localparam int NUM_SPR    = 8;
    localparam int CODE_W     = 2;
    localparam int NUM_PLANES = 6;
    localparam int NUM_GRP    = NUM_SPR / 2;
    localparam int STAT_W     = 16;

    // bit positions inside the status word (decoded by software)
    localparam int B_EVEN_ODD  = 0;
    localparam int B_ODD_BASE  = 1;   // odd planes vs group k at 1+k
    localparam int B_EVEN_BASE = 5;   // even planes vs group k at 5+k
    localparam int B_UNUSED    = 15;

    typedef logic [STAT_W-1:0] clx_stat_t;

    typedef struct packed {
        clx_stat_t stat;
    } clx_state_t;

    // bit index of sprite group pair (a<b)
    function automatic int spr_pair_bit(input int a, input int b);
        int idx;
        idx = 0;
        if (a == 0 && b == 1) idx = 9;
        if (a == 0 && b == 2) idx = 10;
        if (a == 0 && b == 3) idx = 11;
        if (a == 1 && b == 2) idx = 12;
        if (a == 1 && b == 3) idx = 13;
        if (a == 2 && b == 3) idx = 14;
        return idx;
    endfunction
endpackage

// File: rtl/clx_spr_groups.sv
module clx_spr_groups
    import clx_pkg::*;
#(
    parameter int N_SPR = NUM_SPR,
    parameter int C_W   = CODE_W,
    localparam int N_GRP = N_SPR / 2
) (
    input  logic [N_SPR*C_W-1:0] spr_code,
    input  logic [N_GRP-1:0]     odd_en,
    output logic [N_GRP-1:0]     grp_hit
);
    logic [N_SPR-1:0] present;

    for (genvar s = 0; s < N_SPR; s++) begin : g_present
        assign present[s] = |spr_code[s*C_W +: C_W];
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_group
        assign grp_hit[g] = present[2*g] | (present[2*g+1] & odd_en[g]);
    end
endmodule

// File: rtl/clx_plane_groups.sv
module clx_plane_groups
    import clx_pkg::*;
#(
    parameter int N_PL = NUM_PLANES
) (
    input  logic [N_PL-1:0] bits,
    input  logic [N_PL-1:0] en,
    input  logic [N_PL-1:0] match,
    output logic            odd_hit,
    output logic            even_hit
);
    logic [N_PL-1:0] ok;

    // index 0 is plane 1 (odd group)
    for (genvar p = 0; p < N_PL; p++) begin : g_ok
        assign ok[p] = ~en[p] | (bits[p] == match[p]);
    end

    always_comb begin
        odd_hit  = 1'b1;
        even_hit = 1'b1;
        for (int p = 0; p < N_PL; p++) begin
            if ((p % 2) == 0) odd_hit  = odd_hit  & ok[p];
            else              even_hit = even_hit & ok[p];
        end
    end
endmodule

// File: rtl/clx_pair_matrix.sv
module clx_pair_matrix
    import clx_pkg::*;
#(
    parameter int N_GRP = NUM_GRP,
    parameter int W     = STAT_W
) (
    input  logic [N_GRP-1:0] grp,
    input  logic             odd_hit,
    input  logic             even_hit,
    output logic [W-1:0]     hits
);
    always_comb begin
        hits = '0;
        hits[B_EVEN_ODD] = odd_hit & even_hit;
        for (int k = 0; k < N_GRP; k++) begin
            hits[B_ODD_BASE + k]  = odd_hit  & grp[k];
            hits[B_EVEN_BASE + k] = even_hit & grp[k];
        end
        for (int a = 0; a < N_GRP; a++) begin
            for (int b = a + 1; b < N_GRP; b++) begin
                hits[spr_pair_bit(a, b)] = grp[a] & grp[b];
            end
        end
        hits[B_UNUSED] = 1'b0;
    end
endmodule

// File: rtl/collision_latch.sv
module collision_latch
    import clx_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pix_valid,
    input  logic [NUM_PLANES-1:0]      plane_bits,
    input  logic [NUM_SPR*CODE_W-1:0]  spr_code,
    input  logic [NUM_PLANES-1:0]      plane_en,
    input  logic [NUM_PLANES-1:0]      plane_match,
    input  logic [NUM_GRP-1:0]         odd_spr_en,
    input  logic                       rd_en,
    output logic [STAT_W-1:0]          rd_data
);
    logic [NUM_GRP-1:0] grp_hit;
    logic               odd_hit;
    logic               even_hit;
    clx_stat_t          pair_hits;
    clx_state_t         st_d, st_q;
    clx_stat_t          stat_q;

    clx_spr_groups #(.N_SPR(NUM_SPR), .C_W(CODE_W)) u_spr (
        .spr_code (spr_code),
        .odd_en   (odd_spr_en),
        .grp_hit  (grp_hit)
    );

    clx_plane_groups #(.N_PL(NUM_PLANES)) u_pl (
        .bits     (plane_bits),
        .en       (plane_en),
        .match    (plane_match),
        .odd_hit  (odd_hit),
        .even_hit (even_hit)
    );

    clx_pair_matrix #(.N_GRP(NUM_GRP), .W(STAT_W)) u_mx (
        .grp      (grp_hit),
        .odd_hit  (odd_hit),
        .even_hit (even_hit),
        .hits     (pair_hits)
    );

    always_comb begin
        st_d = st_q;
        if (rd_en) st_d.stat = '0;
        if (pix_valid) st_d.stat = st_d.stat | pair_hits;
        st_d.stat[B_UNUSED] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_q  = st_q.stat;
    assign rd_data = rd_en ? stat_q : '0;
endmodule

// File: rtl/clx_checker.sv
module clx_checker
    import clx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pix_valid,
    input logic              rd_en,
    input logic [STAT_W-1:0] rd_data,
    input logic [STAT_W-1:0] stat_q
);
    AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[B_UNUSED] == 1'b0); // R2

    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_valid && !rd_en) |=> stat_q == $past(stat_q)); // R8

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (stat_q & $past(stat_q)) == $past(stat_q)); // R9

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !pix_valid) |=> stat_q == '0); // R10

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == '0); // R10
endmodule

bind collision_latch clx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .stat_q    (stat_q)
);

// File: tb/collision_latch_tb.sv
module collision_latch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic [5:0]  plane_bits = '0;
    logic [15:0] spr_code = '0;
    logic [5:0]  plane_en = '0;
    logic [5:0]  plane_match = '0;
    logic [3:0]  odd_spr_en = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    collision_latch u_dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
        .plane_bits(plane_bits), .spr_code(spr_code),
        .plane_en(plane_en), .plane_match(plane_match),
        .odd_spr_en(odd_spr_en), .rd_en(rd_en), .rd_data(rd_data)
    );

    // {planes, en, match, sprite codes, odd enables, expected}
    localparam int NV = 22;
    localparam logic [53:0] VEC [NV] = '{
        {6'h00, 6'h3F, 6'h3F, 16'h0000, 4'h0, 16'h0000}, // nothing
        {6'h3F, 6'h3F, 6'h3F, 16'h0000, 4'h0, 16'h0001}, // R5 bit0
        {6'h15, 6'h3F, 6'h3F, 16'h0001, 4'h0, 16'h0002}, // R5 bit1
        {6'h15, 6'h3F, 6'h3F, 16'h0010, 4'h0, 16'h0004}, // R5 bit2
        {6'h15, 6'h3F, 6'h3F, 16'h0100, 4'h0, 16'h0008}, // R5 bit3
        {6'h15, 6'h3F, 6'h3F, 16'h1000, 4'h0, 16'h0010}, // R5 bit4
        {6'h2A, 6'h3F, 6'h3F, 16'h0001, 4'h0, 16'h0020}, // R4 bit5
        {6'h2A, 6'h3F, 6'h3F, 16'h0010, 4'h0, 16'h0040}, // R4 bit6
        {6'h2A, 6'h3F, 6'h3F, 16'h0100, 4'h0, 16'h0080}, // R4 bit7
        {6'h2A, 6'h3F, 6'h3F, 16'h2000, 4'h0, 16'h0100}, // R4 bit8
        {6'h00, 6'h3F, 6'h3F, 16'h0011, 4'h0, 16'h0200}, // R3 bit9
        {6'h00, 6'h3F, 6'h3F, 16'h0101, 4'h0, 16'h0400}, // R3 bit10
        {6'h00, 6'h3F, 6'h3F, 16'h1001, 4'h0, 16'h0800}, // R3 bit11
        {6'h00, 6'h3F, 6'h3F, 16'h0110, 4'h0, 16'h1000}, // R3 bit12
        {6'h00, 6'h3F, 6'h3F, 16'h4010, 4'h8, 16'h2000}, // R7 sprite7 in
        {6'h00, 6'h3F, 6'h3F, 16'h4010, 4'h0, 16'h0000}, // R7 sprite7 out
        {6'h00, 6'h3F, 6'h3F, 16'h1100, 4'h0, 16'h4000}, // R3 bit14
        {6'h3F, 6'h3F, 6'h3F, 16'h1111, 4'h0, 16'h7FFF}, // R2 all bits
        {6'h15, 6'h2A, 6'h00, 16'h000C, 4'h1, 16'h0023}, // R6 odd group empty
        {6'h15, 6'h2A, 6'h00, 16'h000C, 4'h0, 16'h0001}, // R7 sprite1 out
        {6'h00, 6'h00, 6'h00, 16'h0440, 4'h6, 16'h10CD}, // R6 none enabled
        {6'h3F, 6'h3F, 6'h00, 16'h0000, 4'h0, 16'h0000}  // R6 match miss
    };

    task automatic check(input string req, input logic [15:0] exp);
        n_vec++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
        end
    endtask

    task automatic set_pixel(input logic [53:0] v, input logic valid);
        @(negedge clk);
        plane_bits  = v[53:48];
        plane_en    = v[47:42];
        plane_match = v[41:36];
        spr_code    = v[35:20];
        odd_spr_en  = v[19:16];
        pix_valid   = valid;
    endtask

    task automatic idle_pixel();
        pix_valid = 1'b0;
        spr_code  = '0;
    endtask

    // read at the next negedge, compare, clear at the following edge
    task automatic do_read(input string req, input logic [15:0] exp);
        @(negedge clk);
        idle_pixel();
        rd_en = 1'b1;
        #1;
        check(req, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        do_read("R1", 16'h0000);

        for (int i = 0; i < NV; i++) begin
            set_pixel(VEC[i], 1'b1);
            do_read($sformatf("vector %0d", i), VEC[i][15:0]);
            do_read("R10 clear", 16'h0000);
        end

        // R8: collisions while blanking are not recorded
        set_pixel({6'h3F, 6'h3F, 6'h3F, 16'h1111, 4'hF, 16'h0}, 1'b0);
        do_read("R8", 16'h0000);

        // R9: accumulation across two pixels
        set_pixel({6'h15, 6'h3F, 6'h3F, 16'h0001, 4'h0, 16'h0}, 1'b1);
        set_pixel({6'h00, 6'h3F, 6'h3F, 16'h0011, 4'h0, 16'h0}, 1'b1);
        @(negedge clk);
        idle_pixel();
        #1;
        check("R10 idle zero", 16'h0000);
        set_pixel({6'h00, 6'h3F, 6'h3F, 16'h0000, 4'h0, 16'h0}, 1'b1);
        do_read("R9", 16'h0202);

        // R11: read and collision in the same cycle
        set_pixel({6'h3F, 6'h3F, 6'h3F, 16'h0000, 4'h0, 16'h0}, 1'b1);
        set_pixel({6'h00, 6'h3F, 6'h3F, 16'h0011, 4'h0, 16'h0}, 1'b1);
        rd_en = 1'b1;
        #1;
        check("R11 old value", 16'h0001);
        @(negedge clk);
        rd_en = 1'b0;
        idle_pixel();
        do_read("R11 new flag", 16'h0200);

        // R1: reset empties the register
        set_pixel({6'h3F, 6'h3F, 6'h3F, 16'h0000, 4'h0, 16'h0}, 1'b1);
        @(negedge clk);
        idle_pixel();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_read("R1 after reset", 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule